// File: doc/BRIEF.md
# Burst-Context Memory Subordinate

This block is a bus subordinate that fronts a small on-chip word memory and serves pipelined, AHB-style transfers. While a burst runs it holds a context made of three parts: a valid flag, the word index it expects next, and a prefetched copy of the word at that index. Beats that continue the context finish with no wait states. Read data for those beats comes straight from the prefetch register.

A paused burst keeps its context. A BUSY beat touches neither the memory nor the context, and it is always answered at once. An IDLE beat, a deselected address phase, or an access at an unexpected address drops the context. The next access then pays one wait state while the context is rebuilt. Masters fed by a source that sometimes runs dry can therefore pause a burst for free, while ending the burst and starting it again costs a cycle.

The transfer encoding on `htrans` is 00 IDLE, 01 BUSY, 10 NONSEQ and 11 SEQ. With the default parameters the memory holds 16 words of 32 bits. The word index is `haddr[5:2]` and the byte offset is `haddr[1:0]`.

Top module: `bctx_mem_sub`

## Requirements
- R1: After reset `hreadyout` is 1 and `hrdata` is 0, no context is held, and every memory word reads back as 0.
- R2: An address phase is taken only in a cycle where `hready` is 1. If `hsel` is 0 in such a cycle, no access is made and any held context is dropped.
- R3: A NONSEQ or SEQ beat that finds no valid context, or whose word index differs from the expected one, gets exactly one wait state: `hreadyout` is 0 in the first cycle of its data phase and 1 in the second.
- R4: A SEQ beat whose word index equals the expected next index (the previous access index plus one) completes in its first data-phase cycle. For a read, `hrdata` carries the current memory word.
- R5: A BUSY beat (`htrans`=01) makes no memory read or write, even when `hwrite` is 1. It leaves the context unchanged, and `hreadyout` stays 1 in the following cycle.
- R6: A SEQ beat after one or more BUSY beats continues the burst with zero wait states and correct read data.
- R7: An IDLE beat (`htrans`=00) with `hsel` at 1 drops the context, so a following access at the old expected index costs one wait state.
- R8: A NONSEQ beat at the expected next index continues the context with no wait. A NONSEQ beat at any other index opens a new context with one wait.
- R9: A SEQ beat at an index other than the expected one rebuilds the context with one wait state.
- R10: A write updates only the byte lanes selected by `hsize` (0 byte, 1 halfword, 2 word) and the byte offset. Lane b holds bits 8b+7..8b, and halfword and word accesses are aligned groups of lanes.
- R11: `hresp` is 0 (OKAY) in every cycle.
- R12: The expected next index wraps from the last word to word 0, so a SEQ beat from the top word to address 0x40 continues with no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Subordinate select for the current address phase |
| haddr | input | ADDR_W | Byte address |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hwrite | input | 1 | 1 write, 0 read |
| hsize | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| hwdata | input | DATA_W | Write data, valid during the data phase |
| hready | input | 1 | Bus ready; an address phase is taken only when high |
| hrdata | output | DATA_W | Read data, valid when a read data phase completes |
| hreadyout | output | 1 | Low for one cycle while a context is rebuilt |
| hresp | output | 1 | Response, always OKAY (0) |

## Verification
The bench runs unbroken write and read bursts, which separate the one-cycle cost of opening a context from the free SEQ beats that follow. Read bursts with BUSY runs are set against the same bursts broken by IDLE: the SEQ beat after BUSY must cost nothing, while the NONSEQ beat after IDLE must cost one wait. Write bursts with BUSY on a write slot, and deselected write phases, show that neither reaches memory. NONSEQ and SEQ beats at matching and non-matching indices, sized writes at each byte offset, and a burst across the top word check the hit decision, the lane selection and the index wrap.

// File: rtl/bctx_pkg.sv
`timescale 1ns/1ps
package bctx_pkg;

    // Transfer type codes on htrans
    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    // Outcome of one address-phase sample
    typedef enum logic [2:0] {
        CAP_NONE = 3'd0,   // no address phase taken this cycle
        CAP_DROP = 3'd1,   // taken, no access, context discarded
        CAP_HOLD = 3'd2,   // taken, no access, context kept (BUSY)
        CAP_HIT  = 3'd3,   // access continuing the held context
        CAP_MISS = 3'd4    // access that must rebuild the context
    } cap_e;

    // True when byte lane 'lane' lies in the naturally aligned group of
    // 2**size bytes that contains byte offset 'off'.
    function automatic logic lane_on(input logic [31:0] lane,
                                     input logic [2:0]  size,
                                     input logic [2:0]  off);
        logic [31:0] o32;
        o32 = {29'd0, off};
        return (lane >> size) == (o32 >> size);
    endfunction

endpackage

// File: rtl/bctx_classify.sv
`timescale 1ns/1ps
module bctx_classify
    import bctx_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             hsel,
    input  logic             hready,
    input  logic [1:0]       htrans,
    input  logic [IDX_W-1:0] idx,
    input  logic             ctx_vld,
    input  logic [IDX_W-1:0] ctx_next,
    output cap_e             kind
);

    trans_e tr;
    logic   match;

    assign tr    = trans_e'(htrans);
    assign match = ctx_vld && (idx == ctx_next);

    always_comb begin
        kind = CAP_NONE;
        if (hready) begin
            if (!hsel) begin
                kind = CAP_DROP;
            end else begin
                unique case (tr)
                    TR_IDLE: kind = CAP_DROP;
                    TR_BUSY: kind = CAP_HOLD;
                    TR_NSEQ,
                    TR_SEQ:  kind = match ? CAP_HIT : CAP_MISS;
                    default: kind = CAP_DROP;
                endcase
            end
        end
    end

endmodule

// File: rtl/bctx_store.sv
`timescale 1ns/1ps
module bctx_store #(
    parameter int DEPTH = 16,
    parameter int NB    = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int DW    = NB * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [NB-1:0]    wmask,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx_a,
    input  logic [IDX_W-1:0] ridx_b,
    output logic [DW-1:0]    rdata_a,
    output logic [DW-1:0]    rdata_b
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) begin
                mem_q[w] <= '0;
            end
        end else if (we) begin
            for (int b = 0; b < NB; b++) begin
                if (wmask[b]) begin
                    mem_q[widx][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end
    end

    assign rdata_a = mem_q[ridx_a];
    assign rdata_b = mem_q[ridx_b];

endmodule

// File: rtl/bctx_mem_sub.sv
`timescale 1ns/1ps
module bctx_mem_sub
    import bctx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic [DATA_W-1:0] hrdata,
    output logic              hreadyout,
    output logic              hresp
);

    localparam int NB    = DATA_W / 8;
    localparam int OFF_W = $clog2(NB);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic              dp_act;   // a data phase is in progress
        logic              dp_wr;    // that data phase is a write
        logic [IDX_W-1:0]  dp_idx;   // word index of the data phase
        logic [NB-1:0]     dp_mask;  // byte lanes of the data phase
        logic              rdy;      // drives hreadyout
        logic              ctx_vld;  // burst context held
        logic [IDX_W-1:0]  ctx_next; // word index expected next
        logic [DATA_W-1:0] pf;       // prefetched word
    } st_t;

    st_t q, d;

    logic [IDX_W-1:0]  a_idx;
    logic [OFF_W-1:0]  a_off;
    logic [NB-1:0]     a_mask;
    cap_e              kind;
    logic              mem_we;
    logic [DATA_W-1:0] rd_cur;
    logic [DATA_W-1:0] rd_nxt;
    logic [IDX_W-1:0]  nxt_idx;
    logic              ctx_vld_w;
    logic [IDX_W-1:0]  ctx_next_w;
    logic              unused_hi;

    assign a_idx     = haddr[OFF_W +: IDX_W];
    assign a_off     = haddr[OFF_W-1:0];
    assign unused_hi = ^haddr[ADDR_W-1:OFF_W+IDX_W];
    assign nxt_idx   = q.dp_idx + IDX_W'(1);

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            a_mask[b] = lane_on(32'(b), hsize, 3'(a_off));
        end
    end

    bctx_classify #(.IDX_W(IDX_W)) cls_i (
        .hsel     (hsel),
        .hready   (hready),
        .htrans   (htrans),
        .idx      (a_idx),
        .ctx_vld  (q.ctx_vld),
        .ctx_next (q.ctx_next),
        .kind     (kind)
    );

    bctx_store #(.DEPTH(DEPTH), .NB(NB)) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .widx    (q.dp_idx),
        .wmask   (q.dp_mask),
        .wdata   (hwdata),
        .ridx_a  (q.dp_idx),
        .ridx_b  (nxt_idx),
        .rdata_a (rd_cur),
        .rdata_b (rd_nxt)
    );

    always_comb begin
        d      = q;
        mem_we = 1'b0;

        // Data phase progress
        if (q.dp_act) begin
            if (!q.rdy) begin
                // Rebuild cycle: fetch the addressed word
                d.pf  = rd_cur;
                d.rdy = 1'b1;
            end else begin
                // Completion: write lands, prefetch the following word
                d.dp_act = 1'b0;
                mem_we   = q.dp_wr;
                d.pf     = rd_nxt;
            end
        end

        // Address phase
        unique case (kind)
            CAP_HIT, CAP_MISS: begin
                d.dp_act   = 1'b1;
                d.dp_wr    = hwrite;
                d.dp_idx   = a_idx;
                d.dp_mask  = a_mask;
                d.rdy      = (kind == CAP_HIT);
                d.ctx_vld  = 1'b1;
                d.ctx_next = a_idx + IDX_W'(1);
            end
            CAP_DROP: d.ctx_vld = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{dp_act: 1'b0, dp_wr: 1'b0, dp_idx: '0, dp_mask: '0,
                   rdy: 1'b1, ctx_vld: 1'b0, ctx_next: '0, pf: '0};
        end else begin
            q <= d;
        end
    end

    assign hrdata     = (q.dp_act && !q.dp_wr && q.rdy) ? q.pf : '0;
    assign hreadyout  = q.rdy;
    assign hresp      = 1'b0;
    assign ctx_vld_w  = q.ctx_vld;
    assign ctx_next_w = q.ctx_next;

endmodule

// File: rtl/bctx_mem_sub_chk.sv
`timescale 1ns/1ps
module bctx_mem_sub_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsel,
    input logic             hready,
    input logic [1:0]       htrans,
    input logic [IDX_W-1:0] idx,
    input logic             hreadyout,
    input logic             ctx_vld,
    input logic [IDX_W-1:0] ctx_next
);

    logic take;
    assign take = hsel && hready;

    // R1: ready comes up out of reset
    p_ready_reset_r1: assert property (@(posedge clk)
        !rst_n |=> hreadyout);

    // R3: a wait state never lasts beyond one cycle
    p_single_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hreadyout |=> hreadyout);

    // R3: opening a context without one held inserts the wait
    p_open_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && htrans == 2'b10 && !ctx_vld) |=> !hreadyout);

    // R4: a beat matching the expected index runs with no wait
    p_hit_nowait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && htrans[1] && ctx_vld && idx == ctx_next) |=> hreadyout);

    // R5: BUSY is answered at once and leaves the context alone
    p_busy_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && htrans == 2'b01) |=>
            (hreadyout && $stable(ctx_vld) && $stable(ctx_next)));

    // R7: IDLE drops the context with no wait
    p_idle_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && htrans == 2'b00) |=> (!ctx_vld && hreadyout));

    // R2: a deselected address phase drops the context
    p_desel_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsel && hready) |=> !ctx_vld);

endmodule

bind bctx_mem_sub bctx_mem_sub_chk #(.IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsel      (hsel),
    .hready    (hready),
    .htrans    (htrans),
    .idx       (a_idx),
    .hreadyout (hreadyout),
    .ctx_vld   (ctx_vld_w),
    .ctx_next  (ctx_next_w)
);

// File: tb/bctx_mem_sub_tb_top.sv
`timescale 1ns/1ps
module bctx_mem_sub_tb_top;

    localparam int DEPTH = 16;
    localparam int MAXB  = 32;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel  = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize  = 3'd2;
    logic [31:0] hwdata = '0;
    logic        hready;
    logic [31:0] hrdata;
    logic        hreadyout;
    logic        hresp;

    always #2 clk = ~clk;   // 250 MHz

    assign hready = hreadyout;

    bctx_mem_sub dut_i (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
        .hready(hready), .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] ref_mem [DEPTH];

    logic        b_sel [MAXB];
    logic [1:0]  b_tr  [MAXB];
    logic [31:0] b_ad  [MAXB];
    logic        b_wr  [MAXB];
    logic [2:0]  b_sz  [MAXB];
    logic [31:0] b_wd  [MAXB];
    int          r_w   [MAXB];
    logic [31:0] r_d   [MAXB];
    int          nb = 0;

    localparam logic [1:0] IDL = 2'b00, BSY = 2'b01, NSQ = 2'b10, SQ = 2'b11;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic add(input logic sel, input logic [1:0] tr, input logic [31:0] ad,
                       input logic wr, input logic [2:0] sz, input logic [31:0] wd);
        b_sel[nb] = sel; b_tr[nb] = tr; b_ad[nb] = ad;
        b_wr[nb] = wr;   b_sz[nb] = sz; b_wd[nb] = wd;
        r_w[nb] = -1;    r_d[nb] = 'x;
        nb++;
    endtask

    // Bench-side model of a sized write
    task automatic ref_write(input logic [31:0] ad, input logic [2:0] sz,
                             input logic [31:0] wd);
        int w = int'(ad[5:2]);
        int o = int'(ad[1:0]);
        for (int b = 0; b < 4; b++) begin
            bit on;
            if (sz == 3'd0)      on = (b == o);
            else if (sz == 3'd1) on = ((b / 2) == (o / 2));
            else                 on = 1'b1;
            if (on) ref_mem[w][b*8 +: 8] = wd[b*8 +: 8];
        end
    endtask

    function automatic logic [31:0] ref_rd(input logic [31:0] ad);
        return ref_mem[ad[5:2]];
    endfunction

    // Runs the queued beats with pipelined address and data phases
    task automatic run();
        int ai = 0;
        int di = -1;
        int wc = 0;
        while (ai < nb || di >= 0) begin
            @(negedge clk);
            hwdata = (di >= 0) ? b_wd[di] : 32'hDEAD_BEEF;
            if (di >= 0) begin
                if (hreadyout) begin
                    r_w[di] = wc;
                    r_d[di] = hrdata;
                    wc = 0;
                    di = -1;
                end else begin
                    wc++;
                end
            end
            if (hreadyout) begin
                if (ai < nb) begin
                    hsel = b_sel[ai]; htrans = b_tr[ai]; haddr = b_ad[ai];
                    hwrite = b_wr[ai]; hsize = b_sz[ai];
                    di = ai;
                    ai++;
                end else begin
                    hsel = 1'b0; htrans = IDL; hwrite = 1'b0;
                end
            end
        end
        nb = 0;
    endtask

    task automatic chk_w(input string req, input int i, input int exp);
        chk(req, $sformatf("beat %0d wait count", i), 32'(r_w[i]), 32'(exp));
    endtask

    task automatic chk_d(input string req, input int i, input logic [31:0] exp);
        chk(req, $sformatf("beat %0d read data", i), r_d[i], exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "hreadyout after reset", 32'(hreadyout), 32'd1);
        chk("R1", "hrdata after reset", hrdata, 32'd0);
        chk("R11", "hresp after reset", 32'(hresp), 32'd0);
        add(1, NSQ, 32'h0000_001C, 0, 3'd2, 0);
        run();
        chk_w("R1", 0, 1);
        chk_d("R1", 0, 32'd0);
    endtask

    task automatic t_burst();
        for (int i = 0; i < 4; i++) begin
            logic [31:0] v = 32'hA000_0000 + 32'(i * 32'h0101);
            add(1, i == 0 ? NSQ : SQ, 32'(i * 4), 1, 3'd2, v);
            ref_write(32'(i * 4), 3'd2, v);
        end
        run();
        chk_w("R3", 0, 1);
        for (int i = 1; i < 4; i++) chk_w("R4", i, 0);
        for (int i = 0; i < 4; i++) add(1, i == 0 ? NSQ : SQ, 32'(i * 4), 0, 3'd2, 0);
        run();
        chk_w("R3", 0, 1);
        for (int i = 1; i < 4; i++) chk_w("R4", i, 0);
        for (int i = 0; i < 4; i++) chk_d("R4", i, ref_rd(32'(i * 4)));
        chk("R11", "hresp after bursts", 32'(hresp), 32'd0);
    endtask

    task automatic t_busy_read();
        add(1, NSQ, 32'h00, 0, 3'd2, 0);
        add(1, BSY, 32'h04, 0, 3'd2, 0);
        add(1, BSY, 32'h04, 0, 3'd2, 0);
        add(1, SQ,  32'h04, 0, 3'd2, 0);
        add(1, SQ,  32'h08, 0, 3'd2, 0);
        run();
        chk_w("R3", 0, 1);
        chk_w("R5", 1, 0);
        chk_w("R5", 2, 0);
        chk_w("R6", 3, 0);
        chk_w("R6", 4, 0);
        chk_d("R6", 3, ref_rd(32'h04));
        chk_d("R6", 4, ref_rd(32'h08));
    endtask

    task automatic t_busy_write();
        add(1, NSQ, 32'h20, 1, 3'd2, 32'h1357_9BDF);
        add(1, BSY, 32'h24, 1, 3'd2, 32'hFFFF_0000);
        add(1, SQ,  32'h24, 1, 3'd2, 32'h2468_ACE0);
        add(1, BSY, 32'h28, 1, 3'd2, 32'hFFFF_1111);
        run();
        ref_write(32'h20, 3'd2, 32'h1357_9BDF);
        ref_write(32'h24, 3'd2, 32'h2468_ACE0);
        chk_w("R5", 1, 0);
        chk_w("R6", 2, 0);
        chk_w("R5", 3, 0);
        add(1, NSQ, 32'h20, 0, 3'd2, 0);
        add(1, SQ,  32'h24, 0, 3'd2, 0);
        add(1, SQ,  32'h28, 0, 3'd2, 0);
        run();
        chk_d("R6", 0, 32'h1357_9BDF);
        chk_d("R6", 1, 32'h2468_ACE0);
        chk_d("R5", 2, ref_rd(32'h28));
    endtask

    task automatic t_idle();
        add(1, NSQ, 32'h00, 0, 3'd2, 0);
        add(1, SQ,  32'h04, 0, 3'd2, 0);
        add(1, IDL, 32'h08, 0, 3'd2, 0);
        add(1, NSQ, 32'h08, 0, 3'd2, 0);
        run();
        chk_w("R7", 2, 0);
        chk_w("R7", 3, 1);
        chk_d("R7", 3, ref_rd(32'h08));
    endtask

    task automatic t_nonseq();
        add(1, NSQ, 32'h08, 0, 3'd2, 0);
        add(1, NSQ, 32'h0C, 0, 3'd2, 0);
        add(1, NSQ, 32'h20, 0, 3'd2, 0);
        add(1, SQ,  32'h24, 0, 3'd2, 0);
        run();
        chk_w("R8", 1, 0);
        chk_w("R8", 2, 1);
        chk_w("R8", 3, 0);
        chk_d("R8", 1, ref_rd(32'h0C));
        chk_d("R8", 2, ref_rd(32'h20));
        chk_d("R8", 3, ref_rd(32'h24));
    endtask

    task automatic t_seq_miss();
        add(1, NSQ, 32'h00, 0, 3'd2, 0);
        add(1, SQ,  32'h14, 0, 3'd2, 0);
        add(1, SQ,  32'h18, 0, 3'd2, 0);
        run();
        chk_w("R9", 1, 1);
        chk_w("R9", 2, 0);
        chk_d("R9", 1, ref_rd(32'h14));
    endtask

    task automatic t_desel();
        add(1, NSQ, 32'h00, 0, 3'd2, 0);
        add(0, NSQ, 32'h04, 1, 3'd2, 32'h0BAD_0BAD);
        add(1, NSQ, 32'h04, 0, 3'd2, 0);
        run();
        chk_w("R2", 1, 0);
        chk_w("R2", 2, 1);
        chk_d("R2", 2, ref_rd(32'h04));
    endtask

    task automatic t_sizes();
        add(1, NSQ, 32'h30, 1, 3'd2, 32'h1122_3344);
        add(1, NSQ, 32'h31, 1, 3'd0, 32'hAABB_CCDD);
        add(1, NSQ, 32'h32, 1, 3'd1, 32'h5566_7788);
        add(1, NSQ, 32'h30, 1, 3'd0, 32'h0000_00EE);
        run();
        ref_write(32'h30, 3'd2, 32'h1122_3344);
        ref_write(32'h31, 3'd0, 32'hAABB_CCDD);
        ref_write(32'h32, 3'd1, 32'h5566_7788);
        ref_write(32'h30, 3'd0, 32'h0000_00EE);
        add(1, NSQ, 32'h30, 0, 3'd2, 0);
        run();
        chk_d("R10", 0, 32'h5566_CCEE);
        chk("R10", "bench model agrees", ref_rd(32'h30), 32'h5566_CCEE);
    endtask

    task automatic t_wrap();
        add(1, NSQ, 32'h3C, 1, 3'd2, 32'hC0DE_F00D);
        run();
        ref_write(32'h3C, 3'd2, 32'hC0DE_F00D);
        add(1, NSQ, 32'h3C, 0, 3'd2, 0);
        add(1, SQ,  32'h40, 0, 3'd2, 0);
        run();
        chk_w("R12", 1, 0);
        chk_d("R12", 0, 32'hC0DE_F00D);
        chk_d("R12", 1, ref_rd(32'h00));
    endtask

    initial begin
        for (int w = 0; w < DEPTH; w++) ref_mem[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_burst();
        t_busy_read();
        t_busy_write();
        t_idle();
        t_nonseq();
        t_seq_miss();
        t_desel();
        t_sizes();
        t_wrap();
        @(negedge clk);
        chk("R11", "hresp at end", 32'(hresp), 32'd0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (R3 progress): actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule